// File: doc/BRIEF.md
# Paged Nonvolatile Memory Burst Writer

This controller sits on the host side of a byte-wide parallel nonvolatile memory that is programmed in pages. It accepts a command made of a start address, a byte count and a polling-mode select. It then takes the bytes one at a time over a valid/ready stream. Each byte is turned into a static-RAM-style write cycle on the memory pins. The memory latches a group of byte writes that fall on one page and then programs them internally, which takes milliseconds. The controller therefore polls the memory until programming has finished.

A burst that is sent to the memory is closed at three points: when the request runs out of bytes, when the next address would leave the 128-byte page, or when the producer stalls longer than the allowed gap between writes. Once a burst is closed, the controller reads back the last address it wrote. It watches either the top data bit for the true value or the next bit for the end of its toggling. When the memory is ready again, the controller resumes the stream with a fresh burst or signals that the command is finished. If programming does not finish within a bounded number of cycles, the controller flags an error and returns to idle.

Top module: `hpw_page_writer`

## Requirements
- R1: Under reset and after it, all three strobes (`mem_ce_n`, `mem_oe_n`, `mem_we_n`) are high, `mem_drive`, `done` and `timeout_err` are low, `cmd_ready` is high and `dat_ready` is low.
- R2: Every byte write holds `mem_oe_n` high and `mem_ce_n` low while `mem_we_n` is low. The write-enable low pulse lasts exactly PULSE_CYC cycles. Address and write data stay stable for the whole pulse.
- R3: The n-th byte accepted on the data stream (n counted from 0) is written to address `cmd_addr + n`. The value stored there after completion is that byte.
- R4: All writes of one burst share address bits [16:7]. A burst holds at most 128 bytes. A request that crosses a 128-byte page boundary is split: the first part is closed and polled to completion before any byte of the next page is written.
- R5: Once a burst has begun, if no byte arrives within GAP_LIM cycles after a write completes, the burst is closed and polling starts. As a result, the memory never sees consecutive writes of one burst spaced further apart than its own inter-byte limit.
- R6: With `poll_mode` = 0, completion is taken when a read of the last written address returns bit 7 equal to bit 7 of the last byte written.
- R7: With `poll_mode` = 1, completion is taken when two successive reads of the last written address return the same bit 6.
- R8: A poll read drives `mem_oe_n` low, `mem_we_n` high, `mem_drive` low and the address of the last byte written. `dat_ready` is low throughout polling.
- R9: `done` pulses for one cycle only after the final burst of a command has completed, and never while the memory is still programming. `cmd_ready` is high in that same cycle.
- R10: If completion is not seen within TIMEOUT cycles of the start of polling, `timeout_err` pulses for one cycle, `done` stays low, and the controller is idle (`cmd_ready` high) in that cycle.
- R11: Exactly `cmd_count` bytes are accepted per command. `dat_ready` is never high together with `cmd_ready`. While idle, a valid byte is not accepted and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| poll_mode | input | 1 | Completion method, taken with the command: 0 = bit 7 match, 1 = bit 6 toggle stop |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command taken when both are high |
| cmd_addr | input | ADDR_W | First byte address |
| cmd_count | input | CNT_W | Number of bytes to write |
| dat_valid | input | 1 | Byte offered |
| dat_ready | output | 1 | Byte taken when both are high |
| dat_byte | input | 8 | Byte to write |
| done | output | 1 | One-cycle pulse: command fully programmed |
| timeout_err | output | 1 | One-cycle pulse: polling gave up |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | 8 | Write data toward the memory |
| mem_drive | output | 1 | High while the controller should drive the data bus |
| mem_din | input | 8 | Read data from the memory |

## Verification
The bench pairs the controller with a behavioural memory that latches writes into a page load. That memory starts programming on the first read or when its gap limit expires. While busy it returns inverted bit 7 and a bit 6 that flips on every read. A short in-page burst in each polling mode separates the two completion rules. A request that starts four bytes before a page end, and a full 128-byte page, separate page splitting from the count limit. A producer stall in the middle of a burst shows that the gap rule closes the burst instead of letting the memory time out. A programming time longer than the timeout, and a byte offered while idle, cover the error path and the ignored input.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

    localparam int DATA_W     = 8;
    localparam int MATCH_BIT  = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_POLL_RD,
        S_POLL_GAP
    } hpw_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hpw_pacer.sv
// Down counter used for phase lengths and the poll timeout.
module hpw_pacer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R5 R10: a loaded count only moves downward by one per cycle
    a_r10_pacer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) && !$past(zero) |-> !zero || $past(cnt_q) == W'(1));

endmodule

// File: rtl/hpw_addr_step.sv
// Holds the write address and flags the last byte of a page.
module hpw_addr_step #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              page_last
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)
            addr_d = load_addr;
        else if (advance)
            addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr      = addr_q;
    assign page_last = &addr_q[PAGE_W-1:0];

    // R3: advancing moves to the next byte address
    a_r3_advance_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> addr_q == $past(addr_q) + 1'b1);

endmodule

// File: rtl/hpw_poll_judge.sv
// Decides completion from a poll sample in either mode.
module hpw_poll_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic mode,
    input  logic b7_now,
    input  logic b6_now,
    input  logic b7_expect,
    output logic hit
);
    logic prev6_d, prev6_q;
    logic have_d, have_q;

    always_comb begin
        prev6_d = prev6_q;
        have_d  = have_q;
        if (clear) begin
            have_d = 1'b0;
        end else if (sample) begin
            prev6_d = b6_now;
            have_d  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev6_q <= 1'b0;
            have_q  <= 1'b0;
        end else begin
            prev6_q <= prev6_d;
            have_q  <= have_d;
        end
    end

    assign hit = mode ? (have_q && (b6_now == prev6_q)) : (b7_now == b7_expect);

    // R7: toggle mode never reports completion from a first read
    a_r7_needs_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        mode && !have_q |-> !hit);

endmodule

// File: rtl/hpw_page_writer.sv
module hpw_page_writer
    import hpw_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int PAGE_W    = 7,
    parameter int CNT_W     = 9,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1,
    parameter int READ_CYC  = 2,
    parameter int GAP_LIM   = 16,
    parameter int TIMEOUT   = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_mode,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_byte,
    output logic              done,
    output logic              timeout_err,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_drive,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int PH_MAX = max_of(max_of(max_of(SETUP_CYC, PULSE_CYC),
                                          max_of(HOLD_CYC, READ_CYC)), GAP_LIM);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int TO_W   = $clog2(TIMEOUT + 1);

    typedef struct packed {
        hpw_state_e        st;
        logic [CNT_W-1:0]  remain;
        logic [ADDR_W-1:0] last_addr;
        logic              last_b7;
        logic              open;
        logic              mode;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] dout;
    } ctl_t;

    ctl_t d, q;

    logic            ph_load, ph_zero;
    logic [PH_W-1:0] ph_val;
    logic            to_load, to_zero;
    logic            jd_clear, jd_sample, hit;
    logic            at_load, at_adv, page_last;
    logic [ADDR_W-1:0] cur_addr;
    logic            unused_din;

    assign unused_din = ^mem_din[TOGGLE_BIT-1:0];

    hpw_pacer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    hpw_pacer #(.W(TO_W)) u_timeout (
        .clk(clk), .rst_n(rst_n), .load(to_load), .load_val(TO_W'(TIMEOUT - 1)), .zero(to_zero)
    );

    hpw_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(at_load), .load_addr(cmd_addr),
        .advance(at_adv), .addr(cur_addr), .page_last(page_last)
    );

    hpw_poll_judge u_judge (
        .clk(clk), .rst_n(rst_n), .clear(jd_clear), .sample(jd_sample), .mode(q.mode),
        .b7_now(mem_din[MATCH_BIT]), .b6_now(mem_din[TOGGLE_BIT]),
        .b7_expect(q.last_b7), .hit(hit)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        ph_load   = 1'b0;
        ph_val    = '0;
        to_load   = 1'b0;
        jd_clear  = 1'b0;
        jd_sample = 1'b0;
        at_load   = 1'b0;
        at_adv    = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    at_load  = 1'b1;
                    d.remain = cmd_count;
                    d.mode   = poll_mode;
                    d.open   = 1'b0;
                    if (cmd_count == '0) d.done = 1'b1;
                    else                 d.st   = S_WAIT;
                end
            end
            S_WAIT: begin
                if (dat_valid) begin
                    d.dout  = dat_byte;
                    d.st    = S_SETUP;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(SETUP_CYC - 1);
                end else if (q.open && ph_zero) begin
                    d.st     = S_POLL_RD;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(READ_CYC - 1);
                    to_load  = 1'b1;
                    jd_clear = 1'b1;
                end
            end
            S_SETUP: begin
                if (ph_zero) begin
                    d.st    = S_PULSE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(PULSE_CYC - 1);
                end
            end
            S_PULSE: begin
                if (ph_zero) begin
                    d.st    = S_HOLD;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(HOLD_CYC - 1);
                end
            end
            S_HOLD: begin
                if (ph_zero) begin
                    d.last_addr = cur_addr;
                    d.last_b7   = q.dout[MATCH_BIT];
                    d.remain    = q.remain - 1'b1;
                    d.open      = 1'b1;
                    at_adv      = 1'b1;
                    ph_load     = 1'b1;
                    if (q.remain == CNT_W'(1) || page_last) begin
                        d.st     = S_POLL_RD;
                        ph_val   = PH_W'(READ_CYC - 1);
                        to_load  = 1'b1;
                        jd_clear = 1'b1;
                    end else begin
                        d.st   = S_WAIT;
                        ph_val = PH_W'(GAP_LIM - 1);
                    end
                end
            end
            S_POLL_RD: begin
                if (ph_zero && hit) begin
                    jd_sample = 1'b1;
                    d.open    = 1'b0;
                    if (q.remain == '0) begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end else begin
                        d.st   = S_WAIT;
                    end
                end else if (to_zero) begin
                    d.err  = 1'b1;
                    d.open = 1'b0;
                    d.st   = S_IDLE;
                end else if (ph_zero) begin
                    jd_sample = 1'b1;
                    d.st      = S_POLL_GAP;
                    ph_load   = 1'b1;
                    ph_val    = '0;
                end
            end
            S_POLL_GAP: begin
                if (to_zero) begin
                    d.err  = 1'b1;
                    d.open = 1'b0;
                    d.st   = S_IDLE;
                end else if (ph_zero) begin
                    d.st    = S_POLL_RD;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(READ_CYC - 1);
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready   = (q.st == S_IDLE);
    assign dat_ready   = (q.st == S_WAIT);
    assign done        = q.done;
    assign timeout_err = q.err;
    assign mem_we_n    = (q.st != S_PULSE);
    assign mem_oe_n    = (q.st != S_POLL_RD);
    assign mem_drive   = (q.st == S_SETUP) || (q.st == S_PULSE) || (q.st == S_HOLD);
    assign mem_ce_n    = !(mem_drive || (q.st == S_POLL_RD));
    assign mem_addr    = (q.st == S_POLL_RD || q.st == S_POLL_GAP) ? q.last_addr : cur_addr;
    assign mem_dout    = q.dout;

    // R2: write enable only pulses inside a selected, output-disabled cycle
    a_r2_write_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n && mem_oe_n);

    // R2: address and data frozen across the pulse
    a_r2_bus_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n && $past(!mem_we_n) |-> $stable(mem_addr) && $stable(mem_dout));

    // R4: a write inside an open burst stays on the burst's page
    a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) && q.open |->
            mem_addr[ADDR_W-1:PAGE_W] == q.last_addr[ADDR_W-1:PAGE_W]);

    // R8: reads leave the data bus to the memory and stop the stream
    a_r8_quiet_bus_when_reading: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_drive && !dat_ready && mem_we_n);

    // R9 R10: completion and error never coincide
    a_r9_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err));

    // R10: an error leaves the controller idle
    a_r10_err_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> cmd_ready);

    // R11: only one side of the request interface is open at a time
    a_r11_one_side_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && dat_ready));

endmodule

// File: tb/tb_hpw_page_writer.sv
module tb_hpw_page_writer;

    localparam int ADDR_W    = 17;
    localparam int CNT_W     = 9;
    localparam int SETUP_CYC = 2;
    localparam int PULSE_CYC = 3;
    localparam int HOLD_CYC  = 1;
    localparam int READ_CYC  = 2;
    localparam int GAP_LIM   = 16;
    localparam int TIMEOUT   = 600;
    localparam int MEM_BLC   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              poll_mode = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CNT_W-1:0]  cmd_count = '0;
    logic              dat_valid = 1'b0;
    logic              dat_ready;
    logic [7:0]        dat_byte = '0;
    logic              done, timeout_err;
    logic              mem_ce_n, mem_oe_n, mem_we_n, mem_drive;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_dout;
    logic [7:0]        mem_din = '0;

    hpw_page_writer #(
        .ADDR_W(ADDR_W), .PAGE_W(7), .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC),
        .GAP_LIM(GAP_LIM), .TIMEOUT(TIMEOUT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .poll_mode(poll_mode), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .done(done), .timeout_err(timeout_err), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_drive(mem_drive), .mem_din(mem_din)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0] mem [int];
    int   pend_a[$];
    logic [7:0] pend_d[$];
    bit   loading = 0, busy = 0, tog = 0;
    int   gap = 0, load_cnt = 0, prog_left = 0, prog_len = 200;
    int   loads = 0, n_writes = 0, we_low = 0;
    int   load_page = 0, last_a = 0;
    logic [7:0] last_d = '0;
    logic prev_we = 1'b1, prev_oe = 1'b1;

    task automatic commit();
        loading   = 0;
        busy      = 1;
        prog_left = prog_len;
        loads++;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            // read start: programming begins, toggle bit flips
            if (!mem_oe_n && !mem_ce_n && prev_oe) begin
                if (loading) commit();
                tog = ~tog;
            end
            if (!mem_we_n) we_low++;
            if (mem_we_n && !prev_we) begin
                chk(we_low == PULSE_CYC, "R2", "write pulse width", we_low, PULSE_CYC);
                chk(!busy, "R9", "write while memory programming", busy, 0);
                if (loading) begin
                    chk(gap <= MEM_BLC, "R5", "gap between writes", gap, MEM_BLC);
                    chk((int'(mem_addr) >> 7) == load_page, "R4", "page of write",
                        int'(mem_addr) >> 7, load_page);
                end else begin
                    loading   = 1;
                    load_page = int'(mem_addr) >> 7;
                    load_cnt  = 0;
                end
                load_cnt++;
                chk(load_cnt <= 128, "R4", "bytes in one load", load_cnt, 128);
                pend_a.push_back(int'(mem_addr));
                pend_d.push_back(mem_dout);
                last_a = int'(mem_addr);
                last_d = mem_dout;
                gap = 0;
                n_writes++;
                we_low = 0;
            end else if (loading) begin
                gap++;
                if (gap > MEM_BLC) commit();
            end
            if (busy) begin
                prog_left--;
                if (prog_left <= 0) begin
                    busy = 0;
                    while (pend_a.size() > 0) mem[pend_a.pop_front()] = pend_d.pop_front();
                end
            end
            if (!mem_ce_n && !mem_oe_n)
                mem_din = (busy || loading) ? {~last_d[7], tog, last_d[5:0]}
                        : (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hFF);
            else
                mem_din = 8'h00;
            // per-clock protocol comparison
            if (!mem_we_n)
                chk(!mem_ce_n && mem_oe_n, "R2", "strobes during write",
                    {mem_ce_n, mem_oe_n}, 2'b01);
            if (!mem_oe_n) begin
                chk(!dat_ready && !mem_drive && mem_we_n, "R8", "bus during poll read",
                    {dat_ready, mem_drive, mem_we_n}, 3'b001);
                chk(int'(mem_addr) == last_a, "R8", "poll address", mem_addr, last_a);
            end
            if (cmd_ready)
                chk(!dat_ready, "R11", "both ready high", dat_ready, 0);
            prev_we = mem_we_n;
            prev_oe = mem_oe_n;
        end
    end

    // ---------------- stimulus helpers ----------------
    int exp_a[$];
    logic [7:0] exp_d[$];
    int accepted = 0;
    bit got_done = 0, got_err = 0;

    task automatic run_cmd(input int a, input int n, input bit m,
                           input int stall_at, input int stall_len, input int seed);
        @(negedge clk);
        cmd_addr  = ADDR_W'(a);
        cmd_count = CNT_W'(n);
        poll_mode = m;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        accepted  = 0;
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) repeat (stall_len) @(negedge clk);
            dat_byte  = 8'(seed + i * 29);
            dat_valid = 1'b1;
            while (!dat_ready) @(negedge clk);
            exp_a.push_back(a + i);
            exp_d.push_back(dat_byte);
            @(negedge clk);
            dat_valid = 1'b0;
            accepted++;
        end
    endtask

    task automatic wait_end(input int limit);
        int k = 0;
        got_done = 0;
        got_err  = 0;
        forever begin
            @(negedge clk);
            if (done || timeout_err) begin
                got_done = done;
                got_err  = timeout_err;
                break;
            end
            k++;
            if (k > limit) break;
        end
    endtask

    task automatic check_contents(input string req);
        while (exp_a.size() > 0) begin
            int a = exp_a.pop_front();
            logic [7:0] v = exp_d.pop_front();
            logic [7:0] got = mem.exists(a) ? mem[a] : 8'hFF;
            chk(got == v, req, $sformatf("stored byte @%0h", a), got, v);
        end
    endtask

    task automatic finish_cmd(input string req, input int exp_loads, input int l0);
        chk(got_done && !got_err, "R9", {"completion of ", req}, {got_done, got_err}, 2'b10);
        chk(!busy && !loading, req, "done before programming ended", busy, 0);
        chk(cmd_ready, "R9", "idle at done", cmd_ready, 1);
        chk(loads - l0 == exp_loads, "R4", {"burst count for ", req}, loads - l0, exp_loads);
        check_contents("R3");
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        int l0;
        int w0;
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_drive} == 4'b1110, "R1", "bus after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_drive}, 4'b1110);
        chk({cmd_ready, dat_ready, done, timeout_err} == 4'b1000, "R1", "handshake after reset",
            {cmd_ready, dat_ready, done, timeout_err}, 4'b1000);

        // R6: bit 7 mode, short in-page burst
        l0 = loads;
        run_cmd(32'h00100, 5, 1'b0, -1, 0, 8'h81);
        chk(accepted == 5, "R11", "bytes accepted", accepted, 5);
        wait_end(5000);
        finish_cmd("R6", 1, l0);

        // R7: toggle mode, burst near top of memory
        l0 = loads;
        run_cmd(32'h1F040, 4, 1'b1, -1, 0, 8'h3C);
        wait_end(5000);
        finish_cmd("R7", 1, l0);

        // R4: request crossing a page boundary
        l0 = loads;
        run_cmd(32'h0007C, 10, 1'b0, -1, 0, 8'h11);
        wait_end(5000);
        finish_cmd("R4", 2, l0);

        // R4: exactly one full page
        l0 = loads;
        run_cmd(32'h00200, 128, 1'b1, -1, 0, 8'h05);
        wait_end(5000);
        finish_cmd("R4", 1, l0);

        // R5: producer stall mid-burst closes the burst
        l0 = loads;
        run_cmd(32'h00400, 6, 1'b0, 3, 50, 8'hA0);
        wait_end(5000);
        finish_cmd("R5", 2, l0);

        // R10: programming longer than the timeout
        prog_len = 2000;
        run_cmd(32'h00600, 2, 1'b0, -1, 0, 8'h77);
        wait_end(5000);
        chk(got_err && !got_done, "R10", "timeout reported", {got_err, got_done}, 2'b10);
        chk(cmd_ready, "R10", "idle at timeout", cmd_ready, 1);
        exp_a.delete();
        exp_d.delete();
        while (busy || loading) @(negedge clk);
        prog_len = 200;

        // R11: a byte offered while idle is ignored
        w0 = n_writes;
        @(negedge clk);
        dat_valid = 1'b1;
        dat_byte  = 8'h5A;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!dat_ready, "R11", "ready while idle", dat_ready, 0);
        end
        dat_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(n_writes == w0, "R11", "writes from idle byte", n_writes - w0, 0);

        // R6 again after recovery, data with bit 7 clear
        l0 = loads;
        run_cmd(32'h00700, 3, 1'b0, -1, 0, 8'h10);
        wait_end(5000);
        finish_cmd("R6", 1, l0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule